// File: doc/BRIEF.md
# Dual Reloadable Down-Counting Timer

This peripheral holds two independent 32-bit down counters behind a small register bus. Each counter decrements by one on every clock while its enable bit is set. A counter is reloaded from its own reload register when it reaches zero, or, when reload is off, it runs once and stops at zero. Software can write a counter's live value register at any time to start a new count. It can also read that register to sample the running count. A rising free-running count is obtained by subtracting the read value from all ones.

Each counter reports an expiry by setting its own cause bit. A mask register selects which cause bits may drive the single interrupt line. Software acknowledges an expiry by writing zeros to the cause bits it wants to clear.

Top module: `dual_down_timer`

## Requirements
- R1: After a synchronous reset (rst_n low at a rising edge), every register reads as zero, both counters are stopped and irq is low.
- R2: The control register at byte address 0x00 maps bit 0 to run timer 0, bit 1 to auto-reload timer 0, bit 2 to run timer 1 and bit 3 to auto-reload timer 1. Bits above bit 3 are not stored and read as zero.
- R3: Timer 0 has its reload register at 0x10 and its value register at 0x14. Timer 1 has its reload register at 0x18 and its value register at 0x1C. The cause register is at 0x04 and the mask register at 0x08; in both, bit 0 belongs to timer 0 and bit 1 to timer 1. Reads of any other address return zero, and writes to any other address change no register.
- R4: While a timer runs and its count is not zero, the count decreases by exactly one per clock, and its value register reads back the live count.
- R5: With auto-reload on and N-1 written to both the reload register and the value register, the timer expires every N clocks. On the clock after the count has reached zero, the count takes the reload value and the cause bit is set.
- R6: With auto-reload on and a reload value of 0xFFFFFFFF, the count wraps from zero to 0xFFFFFFFF and keeps counting down without stopping.
- R7: With auto-reload off, the timer expires once on the clock after it reaches zero and then stays at zero. Its cause bit is not set again until the value register is written.
- R8: Clearing a timer's run bit freezes its count, and the other timer keeps counting.
- R9: A write to the cause register clears each bit written as zero and leaves each bit written as one unchanged. An expiry in the same clock as a clear leaves that cause bit set.
- R10: irq is high exactly when some cause bit and the matching mask bit are both set.
- R11: A write to a value register replaces the count on the next clock, whether the timer is running or not, and that clock produces no expiry for the timer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; each rising edge is one counter tick |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 5 | Byte address of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Interrupt, high when an unmasked cause bit is set |

## Verification
The counting logic is tried in four patterns: a short periodic reload, a one-shot run left idle for many clocks after it expires, a wrapping free-running count, and a continuous expiry from a zero reload. The period measurement tells an off-by-one in the reload timing apart from a correct N-clock period. The idle one-shot shows whether an expiry repeats while the count sits at zero. The continuous expiry under a cause clear exposes which side wins in that clock, and freezing one timer while the other runs shows whether the run bits are crossed. A behavioural model in the bench tracks every register on every clock and is compared with the read port and irq.

// File: rtl/dtmr_pkg.sv
// Package: shared constants for the dual down-counting timer.
// Assumes byte addressing on a 5-bit bus with word-aligned registers.
package dtmr_pkg;
    localparam int NUM_CH  = 2;   // control word layout fixes two channels
    localparam int ADDR_W  = 5;
    localparam int CTRL_BITS_PER_CH = 2;

    localparam logic [ADDR_W-1:0] A_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] A_CAUSE = 5'h04;
    localparam logic [ADDR_W-1:0] A_MASK  = 5'h08;
    localparam logic [ADDR_W-1:0] A_RLD0  = 5'h10;  // channel stride is 8
    localparam logic [ADDR_W-1:0] A_VAL0  = 5'h14;
    localparam int CH_STRIDE = 8;

    typedef struct packed {
        logic run;
        logic autoreload;
    } ch_ctrl_t;
endpackage

// File: rtl/dtmr_channel.sv
// Module: one down counter with reload and one-shot behaviour.
// Assumes load_we is a single-cycle write strobe; a load wins over counting.
module dtmr_channel #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          autoreload,
    input  logic          load_we,
    input  logic [DW-1:0] load_data,
    input  logic [DW-1:0] reload_val,
    output logic [DW-1:0] count,
    output logic          expire
);
    logic [DW-1:0] cnt_q, cnt_d;
    logic          armed_q, armed_d;
    logic          at_zero;

    assign at_zero = (cnt_q == '0);

    // Next-count and expiry decision for this clock.
    always_comb begin
        cnt_d   = cnt_q;
        armed_d = armed_q;
        expire  = 1'b0;
        if (load_we) begin
            cnt_d   = load_data;
            armed_d = 1'b1;
        end else if (run) begin
            if (!at_zero) begin
                cnt_d = cnt_q - 1'b1;
            end else if (autoreload) begin
                cnt_d   = reload_val;
                armed_d = 1'b1;
                expire  = 1'b1;
            end else if (armed_q) begin
                armed_d = 1'b0;
                expire  = 1'b1;
            end
        end
    end

    // Count and arm-flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            cnt_q   <= cnt_d;
            armed_q <= armed_d;
        end
    end

    assign count = cnt_q;

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load_we && count != '0) |=> count == $past(count) - 1'b1); // R4
    AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load_we) |=> $stable(count)); // R8
    AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load_we && count == '0 && autoreload) |=> count == $past(reload_val)); // R5
    AST_ONESHOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load_we && count == '0 && !autoreload) |=> count == '0); // R7
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> count == $past(load_data)); // R11
    AST_LOAD_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |-> !expire); // R11
endmodule

// File: rtl/dtmr_cause.sv
// Module: cause bits with write-zero-to-clear and the masked interrupt.
// Assumes clr_we is a single-cycle strobe; a fresh expiry beats a clear.
module dtmr_cause #(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] expire,
    input  logic           clr_we,
    input  logic [NCH-1:0] clr_data,
    input  logic [NCH-1:0] mask,
    output logic [NCH-1:0] cause,
    output logic           irq
);
    logic [NCH-1:0] cause_q, cause_d, keep;

    // Bits written as zero drop, bits written as one stay.
    always_comb begin
        keep    = clr_we ? clr_data : '1;
        cause_d = (cause_q & keep) | expire;
    end

    // Cause register.
    always_ff @(posedge clk) begin
        if (!rst_n) cause_q <= '0;
        else        cause_q <= cause_d;
    end

    assign cause = cause_q;
    assign irq   = |(cause_q & mask);

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq); // R10

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            expire[g] |=> cause[g]); // R9
        AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && !clr_data[g] && !expire[g]) |=> !cause[g]); // R9
        AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_data[g] && cause[g]) |=> cause[g]); // R9
    end
endmodule

// File: rtl/dtmr_regs.sv
// Module: register decode, control/mask/reload storage and read mux.
// Assumes reads are combinational and unmapped addresses read as zero.
module dtmr_regs
    import dtmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [DW-1:0]           bus_wdata,
    output logic [DW-1:0]           bus_rdata,
    input  logic [NUM_CH-1:0][DW-1:0] counts,
    input  logic [NUM_CH-1:0]       cause,
    output ch_ctrl_t [NUM_CH-1:0]   ctrl,
    output logic [NUM_CH-1:0][DW-1:0] reloads,
    output logic [NUM_CH-1:0]       val_we,
    output logic [NUM_CH-1:0]       mask,
    output logic                    cause_we
);
    localparam int CTRL_W = NUM_CH * CTRL_BITS_PER_CH;

    logic [CTRL_W-1:0]          ctrl_q;
    logic [NUM_CH-1:0]          mask_q;
    logic [NUM_CH-1:0][DW-1:0]  rld_q;
    logic [NUM_CH-1:0]          rld_we;

    // Per-channel address match for reload and value registers.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        localparam logic [ADDR_W-1:0] A_R = ADDR_W'(int'(A_RLD0) + CH_STRIDE * g);
        localparam logic [ADDR_W-1:0] A_V = ADDR_W'(int'(A_VAL0) + CH_STRIDE * g);
        assign rld_we[g] = bus_we && (bus_addr == A_R);
        assign val_we[g] = bus_we && (bus_addr == A_V);
        assign ctrl[g].run        = ctrl_q[CTRL_BITS_PER_CH*g];
        assign ctrl[g].autoreload = ctrl_q[CTRL_BITS_PER_CH*g + 1];

        // Reload register storage for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)         rld_q[g] <= '0;
            else if (rld_we[g]) rld_q[g] <= bus_wdata;
        end
    end

    assign cause_we = bus_we && (bus_addr == A_CAUSE);

    // Control and mask register storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
            if (bus_addr == A_MASK) mask_q <= bus_wdata[NUM_CH-1:0];
        end
    end

    assign reloads = rld_q;
    assign mask    = mask_q;

    // Read data selection.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_CTRL)  bus_rdata[CTRL_W-1:0] = ctrl_q;
        if (bus_addr == A_CAUSE) bus_rdata[NUM_CH-1:0] = cause;
        if (bus_addr == A_MASK)  bus_rdata[NUM_CH-1:0] = mask_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(int'(A_RLD0) + CH_STRIDE * i)) bus_rdata = rld_q[i];
            if (bus_addr == ADDR_W'(int'(A_VAL0) + CH_STRIDE * i)) bus_rdata = counts[i];
        end
    end

    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_CTRL) |-> bus_rdata[DW-1:CTRL_W] == '0); // R2
    AST_RELOAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        rld_we[0] |=> reloads[0] == $past(bus_wdata)); // R3
endmodule

// File: rtl/dual_down_timer.sv
// Module: top of the dual reloadable down-counting timer.
// Assumes one clock edge per tick and a single-cycle register write strobe.
module dual_down_timer
    import dtmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq
);
    ch_ctrl_t [NUM_CH-1:0]     ctrl;
    logic [NUM_CH-1:0][DW-1:0] reloads;
    logic [NUM_CH-1:0][DW-1:0] counts;
    logic [NUM_CH-1:0]         val_we;
    logic [NUM_CH-1:0]         expire;
    logic [NUM_CH-1:0]         mask;
    logic [NUM_CH-1:0]         cause;
    logic                      cause_we;

    dtmr_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .counts(counts), .cause(cause),
        .ctrl(ctrl), .reloads(reloads), .val_we(val_we),
        .mask(mask), .cause_we(cause_we)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dtmr_channel #(.DW(DW)) u_ch (
            .clk(clk), .rst_n(rst_n),
            .run(ctrl[g].run), .autoreload(ctrl[g].autoreload),
            .load_we(val_we[g]), .load_data(bus_wdata),
            .reload_val(reloads[g]), .count(counts[g]), .expire(expire[g])
        );
    end

    dtmr_cause #(.NCH(NUM_CH)) u_cause (
        .clk(clk), .rst_n(rst_n), .expire(expire),
        .clr_we(cause_we), .clr_data(bus_wdata[NUM_CH-1:0]),
        .mask(mask), .cause(cause), .irq(irq)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !irq); // R1
endmodule

// File: tb/dual_down_timer_tb.sv
`timescale 1ns/1ps
module dual_down_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit live   = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dual_down_timer u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Behavioural reference state.
    logic [3:0]  m_ctrl;
    logic [1:0]  m_cause, m_mask;
    logic [31:0] m_rld [2];
    logic [31:0] m_val [2];
    bit          m_fired [2];

    always @(posedge clk) begin
        logic [1:0] ev;
        logic [1:0] keep;
        cyc++;
        live = 1;
        if (!rst_n) begin
            m_ctrl = 0; m_cause = 0; m_mask = 0;
            for (int i = 0; i < 2; i++) begin m_rld[i] = 0; m_val[i] = 0; m_fired[i] = 1; end
        end else begin
            ev = 0;
            for (int i = 0; i < 2; i++) begin
                if (bus_we && bus_addr == 5'(20 + 8*i)) begin
                    m_val[i] = bus_wdata; m_fired[i] = 0;
                end else if (m_ctrl[2*i]) begin
                    if (m_val[i] != 0) m_val[i] = m_val[i] - 1;
                    else if (m_ctrl[2*i+1]) begin m_val[i] = m_rld[i]; ev[i] = 1; m_fired[i] = 0; end
                    else if (!m_fired[i]) begin ev[i] = 1; m_fired[i] = 1; end
                end
            end
            keep = (bus_we && bus_addr == 5'h04) ? bus_wdata[1:0] : 2'b11;
            m_cause = (m_cause & keep) | ev;
            if (bus_we) begin
                if (bus_addr == 5'h00) m_ctrl = bus_wdata[3:0];
                if (bus_addr == 5'h08) m_mask = bus_wdata[1:0];
                if (bus_addr == 5'h10) m_rld[0] = bus_wdata;
                if (bus_addr == 5'h18) m_rld[1] = bus_wdata;
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [4:0] a);
        case (a)
            5'h00: return {28'd0, m_ctrl};
            5'h04: return {30'd0, m_cause};
            5'h08: return {30'd0, m_mask};
            5'h10: return m_rld[0];
            5'h14: return m_val[0];
            5'h18: return m_rld[1];
            5'h1C: return m_val[1];
            default: return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        case (a)
            5'h00: return "R2";
            5'h04: return "R9";
            5'h08: return "R10";
            5'h14, 5'h1C: return "R4";
            default: return "R3";
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h expected=%h at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    // Cycle-by-cycle comparison against the model.
    always @(negedge clk) begin
        #1;
        if (live && !done) begin
            chk(tag_of(bus_addr), bus_rdata, m_read(bus_addr));
            chk("R10", {31'd0, irq}, {31'd0, |(m_cause & m_mask)});
        end
    end

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk); bus_we = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_we = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk); bus_we = 0; bus_addr = a;
        #1.5; d = bus_rdata;
    endtask

    task automatic wait_irq(output int at);
        do begin @(negedge clk); #1.5; end while (!irq && !done);
        at = cyc;
    endtask

    task automatic finish_run();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #100000;
        checks++; fails++;
        $display("FAIL watchdog R1 got=hung expected=complete");
        finish_run();
    end

    initial begin
        logic [31:0] v, w;
        int a, b;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        rd(5'h00, v); chk("R1", v, 0);
        rd(5'h14, v); chk("R1", v, 0);
        rd(5'h04, v); chk("R1", v, 0);
        rd(5'h08, v); chk("R1", v, 0);
        chk("R1", {31'd0, irq}, 0);

        // R2: only four control bits stored
        wr(5'h00, 32'hFFFF_FFF0); rd(5'h00, v); chk("R2", v, 0);
        // R3: map and unmapped address
        wr(5'h10, 32'h1234); rd(5'h10, v); chk("R3", v, 32'h1234);
        wr(5'h0C, 32'hFFFF); rd(5'h0C, v); chk("R3", v, 0);
        rd(5'h18, v); chk("R3", v, 0);

        // R11: load while stopped
        wr(5'h1C, 32'h55); rd(5'h1C, v); chk("R11", v, 32'h55);
        // R4: decrement by one per clock
        wr(5'h00, 32'h4); rd(5'h1C, v); rd(5'h1C, w); chk("R4", v - w, 1);
        wr(5'h00, 32'h0);

        // R5: periodic, N = 5
        wr(5'h08, 32'h2); wr(5'h18, 32'd4); wr(5'h1C, 32'd4); wr(5'h00, 32'hC);
        wait_irq(a);
        wr(5'h04, 32'h1); rd(5'h04, v); chk("R9", v & 2, 0);
        wait_irq(b); chk("R5", b - a, 5);

        // R9: expiry every clock beats a clear
        wr(5'h18, 32'd0); wr(5'h1C, 32'd0);
        wr(5'h04, 32'h0); rd(5'h04, v); chk("R9", v, 2);
        wr(5'h00, 32'h0); wr(5'h04, 32'h0);
        rd(5'h04, v); chk("R9", v, 0); chk("R10", {31'd0, irq}, 0);

        // R7: one-shot timer 0
        wr(5'h08, 32'h1); wr(5'h14, 32'd6); wr(5'h00, 32'h1);
        wait_irq(a);
        wr(5'h04, 32'h2);
        repeat (20) @(negedge clk);
        rd(5'h04, v); chk("R7", v, 0);
        rd(5'h14, v); chk("R7", v, 0);
        chk("R7", {31'd0, irq}, 0);
        wr(5'h14, 32'd2); wait_irq(b); chk("R7", {31'd0, irq}, 1);

        // R10: mask gates the cause
        wr(5'h08, 32'h0); rd(5'h04, v); chk("R10", v, 1); chk("R10", {31'd0, irq}, 0);
        wr(5'h08, 32'h1); rd(5'h04, v); chk("R10", {31'd0, irq}, 1);
        wr(5'h04, 32'h0);

        // R6: free-running wrap
        wr(5'h00, 32'h0); wr(5'h10, 32'hFFFF_FFFF); wr(5'h14, 32'd3); wr(5'h00, 32'h3);
        repeat (10) @(negedge clk);
        rd(5'h14, v); chk("R6", {31'd0, v > 32'hFFFF_FF00}, 1);

        // R8: stop timer 0, timer 1 keeps counting
        wr(5'h18, 32'd1000); wr(5'h1C, 32'd1000); wr(5'h00, 32'hF);
        wr(5'h00, 32'hC);
        rd(5'h14, v); repeat (3) @(negedge clk); rd(5'h14, w); chk("R8", w, v);
        rd(5'h1C, v); rd(5'h1C, w); chk("R8", v - w, 1);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule